// File: doc/BRIEF.md
# Data Rate Clock Prescaler

This block divides a fixed reference clock into the timing base of a disk data channel. The host writes a two-bit rate code into a small register. The block turns that code into three things. The first is a one-cycle internal tick whose period matches the selected bit rate. The second is a write-data pulse of a minimum width that also depends on the rate. The third is a density-select level whose polarity is set by two board straps.

A newly written rate is not applied at once. It waits in a pending register until the current tick period ends, so the tick stream never shows a shortened interval. The active rate is reported on `rate_code` for the rest of the datapath. Every output comes straight from a flop.

Top module: `rate_clk_div`

## Requirements
- R1: While `rst` is high, and in the cycle after it, `rate_code` is 2'b00, `tick` is low and `wr_pulse` is low.
- R2: `tick` is high for exactly one clock cycle. The distance between consecutive ticks is 3, 6, 10 or 12 clock cycles for active codes 2'b11 (1 Mbps), 2'b00 (500 Kbps), 2'b01 (300 Kbps) and 2'b10 (250 Kbps). The code that sets each interval is the one `rate_code` shows while the tick that opens the interval is high.
- R3: A code written with `rate_we` is adopted only at a tick boundary, so `rate_code` changes only in a cycle where `tick` is high. When several writes land within one tick period, only the last one takes effect.
- R4: A `wr_trig` sampled while `wr_pulse` is low raises `wr_pulse` in the next cycle. The pulse then stays high for 5, 10, 16 or 19 cycles for active code 2'b11, 2'b00, 2'b01 or 2'b10, taken at the trigger.
- R5: `wr_trig` sampled while `wr_pulse` is high has no effect on the running pulse. `wr_pulse` never rises without a trigger.
- R6: With `ident` low and `invert` low, `dens_sel` is 1 for codes 2'b01 and 2'b10, and 0 for codes 2'b00 and 2'b11.
- R7: With `ident` high, the `dens_sel` level of R6 is reversed.
- R8: `invert` high flips the final `dens_sel`. `dens_sel` is registered and reflects `rate_code` and the straps one cycle later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous active-high reset |
| rate_we | input | 1 | Write strobe for the rate register |
| rate_wdata | input | 2 | Rate code to write |
| ident | input | 1 | Polarity mode strap for density select |
| invert | input | 1 | Final inversion strap for density select |
| wr_trig | input | 1 | Starts a write-data pulse |
| tick | output | 1 | One-cycle internal tick enable |
| wr_pulse | output | 1 | Minimum-width write-data pulse |
| rate_code | output | 2 | Active rate code |
| dens_sel | output | 1 | Density-select output |

## Verification
Several properties are checked on every cycle. Each tick lasts one cycle, and each tick gap matches the code shown at the previous tick. `rate_code` moves only on a tick. A pulse rises only after a trigger and falls after the width captured at its start. `dens_sel` follows the registered strap and rate mapping. Some behaviour only the bench scenarios can show: that the code the host writes is the one that lands, in order, with the last of two fast writes winning. They also show that a retrigger leaves the pulse width unchanged, and they step through all sixteen strap and rate combinations of the density output.

// File: rtl/rdiv_pkg.sv
package rdiv_pkg;

  typedef enum logic [1:0] {
    RATE_500 = 2'b00,
    RATE_300 = 2'b01,
    RATE_250 = 2'b10,
    RATE_1M  = 2'b11
  } rate_e;

  // Pick the per-rate value out of four candidates
  function automatic int pick(rate_e r, int v1m, int v500, int v300, int v250);
    case (r)
      RATE_1M:  return v1m;
      RATE_300: return v300;
      RATE_250: return v250;
      default:  return v500;
    endcase
  endfunction

  function automatic int max4(int a, int b, int c, int d);
    int m;
    m = a;
    if (b > m) m = b;
    if (c > m) m = c;
    if (d > m) m = d;
    return m;
  endfunction

  // Low rates (250/300) form the "slow" density group
  function automatic logic slow_rate(rate_e r);
    return (r == RATE_300) || (r == RATE_250);
  endfunction

endpackage

// File: rtl/rdiv_tick_gen.sv
module rdiv_tick_gen
  import rdiv_pkg::*;
#(
  parameter int DIV_1M  = 3,
  parameter int DIV_500 = 6,
  parameter int DIV_300 = 10,
  parameter int DIV_250 = 12,
  parameter int CW      = 4
) (
  input  logic  clk,
  input  logic  rst,
  input  rate_e pend,
  output logic  tick,
  output rate_e active
);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] last_c;
  rate_e         active_q;
  logic          tick_q;

  always_comb begin
    last_c = CW'(pick(active_q, DIV_1M, DIV_500, DIV_300, DIV_250) - 1);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q    <= '0;
      active_q <= RATE_500;
      tick_q   <= 1'b0;
    end else if (cnt_q == last_c) begin
      cnt_q    <= '0;
      active_q <= pend;
      tick_q   <= 1'b1;
    end else begin
      cnt_q    <= cnt_q + CW'(1);
      tick_q   <= 1'b0;
    end
  end

  assign tick   = tick_q;
  assign active = active_q;

endmodule

// File: rtl/rdiv_wpulse.sv
module rdiv_wpulse
  import rdiv_pkg::*;
#(
  parameter int WID_1M  = 5,
  parameter int WID_500 = 10,
  parameter int WID_300 = 16,
  parameter int WID_250 = 19,
  parameter int WW      = 5
) (
  input  logic  clk,
  input  logic  rst,
  input  logic  trig,
  input  rate_e rate,
  output logic  pulse
);

  logic [WW-1:0] wcnt_q;
  logic [WW-1:0] wcnt_d;
  logic          pulse_q;

  always_comb begin
    if (trig && (wcnt_q == '0))
      wcnt_d = WW'(pick(rate, WID_1M, WID_500, WID_300, WID_250));
    else if (wcnt_q != '0)
      wcnt_d = wcnt_q - WW'(1);
    else
      wcnt_d = wcnt_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wcnt_q  <= '0;
      pulse_q <= 1'b0;
    end else begin
      wcnt_q  <= wcnt_d;
      pulse_q <= (wcnt_d != '0);
    end
  end

  assign pulse = pulse_q;

endmodule

// File: rtl/rdiv_dens.sv
module rdiv_dens
  import rdiv_pkg::*;
(
  input  logic  clk,
  input  rate_e rate,
  input  logic  ident,
  input  logic  invert,
  output logic  dens
);

  logic base;
  logic dens_q;

  always_comb begin
    base = ident ? !slow_rate(rate) : slow_rate(rate);
  end

  always_ff @(posedge clk) begin
    dens_q <= base ^ invert;
  end

  assign dens = dens_q;

endmodule

// File: rtl/rate_clk_div.sv
module rate_clk_div
  import rdiv_pkg::*;
#(
  parameter int DIV_1M  = 3,
  parameter int DIV_500 = 6,
  parameter int DIV_300 = 10,
  parameter int DIV_250 = 12,
  parameter int WID_1M  = 5,
  parameter int WID_500 = 10,
  parameter int WID_300 = 16,
  parameter int WID_250 = 19
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       rate_we,
  input  logic [1:0] rate_wdata,
  input  logic       ident,
  input  logic       invert,
  input  logic       wr_trig,
  output logic       tick,
  output logic       wr_pulse,
  output logic [1:0] rate_code,
  output logic       dens_sel
);

  localparam int MAX_DIV = max4(DIV_1M, DIV_500, DIV_300, DIV_250);
  localparam int MAX_WID = max4(WID_1M, WID_500, WID_300, WID_250);
  localparam int CW      = (MAX_DIV < 2) ? 1 : $clog2(MAX_DIV);
  localparam int WW      = $clog2(MAX_WID + 1);

  rate_e pend_q;
  rate_e active;

  always_ff @(posedge clk) begin
    if (rst)          pend_q <= RATE_500;
    else if (rate_we) pend_q <= rate_e'(rate_wdata);
  end

  rdiv_tick_gen #(
    .DIV_1M(DIV_1M), .DIV_500(DIV_500), .DIV_300(DIV_300), .DIV_250(DIV_250), .CW(CW)
  ) u_tick (
    .clk(clk), .rst(rst), .pend(pend_q), .tick(tick), .active(active)
  );

  rdiv_wpulse #(
    .WID_1M(WID_1M), .WID_500(WID_500), .WID_300(WID_300), .WID_250(WID_250), .WW(WW)
  ) u_wp (
    .clk(clk), .rst(rst), .trig(wr_trig), .rate(active), .pulse(wr_pulse)
  );

  rdiv_dens u_dens (
    .clk(clk), .rate(active), .ident(ident), .invert(invert), .dens(dens_sel)
  );

  assign rate_code = active;

endmodule

// File: rtl/rdiv_chk.sv
module rdiv_chk
  import rdiv_pkg::*;
#(
  parameter int DIV_1M  = 3,
  parameter int DIV_500 = 6,
  parameter int DIV_300 = 10,
  parameter int DIV_250 = 12,
  parameter int WID_1M  = 5,
  parameter int WID_500 = 10,
  parameter int WID_300 = 16,
  parameter int WID_250 = 19
) (
  input logic       clk,
  input logic       rst,
  input logic       ident,
  input logic       invert,
  input logic       wr_trig,
  input logic       tick,
  input logic       wr_pulse,
  input logic [1:0] rate_code,
  input logic       dens_sel
);

  logic [15:0] gap_q;
  logic [15:0] per_q;
  logic [15:0] hi_q;
  logic [15:0] wexp_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      gap_q  <= '0;
      per_q  <= 16'(DIV_500);
      hi_q   <= '0;
      wexp_q <= '0;
    end else begin
      gap_q <= tick ? 16'd1 : gap_q + 16'd1;
      if (tick) per_q <= 16'(pick(rate_e'(rate_code), DIV_1M, DIV_500, DIV_300, DIV_250));
      hi_q  <= wr_pulse ? hi_q + 16'd1 : 16'd0;
      if (wr_trig && !wr_pulse)
        wexp_q <= 16'(pick(rate_e'(rate_code), WID_1M, WID_500, WID_300, WID_250));
    end
  end

  AST_RESET_STATE: assert property (@(posedge clk)
    rst |=> (!tick && !wr_pulse && rate_code == 2'b00)); // R1
  AST_TICK_SINGLE: assert property (@(posedge clk) disable iff (rst)
    tick |=> !tick); // R2
  AST_TICK_PERIOD: assert property (@(posedge clk) disable iff (rst)
    tick |-> (gap_q == per_q)); // R2
  AST_RATE_AT_TICK: assert property (@(posedge clk) disable iff (rst)
    (rate_code != $past(rate_code)) |-> tick); // R3
  AST_WP_FROM_TRIG: assert property (@(posedge clk) disable iff (rst)
    $rose(wr_pulse) |-> $past(wr_trig)); // R5
  AST_WP_WIDTH: assert property (@(posedge clk) disable iff (rst)
    $fell(wr_pulse) |-> (hi_q == wexp_q)); // R4
  AST_DENS_MAP: assert property (@(posedge clk) disable iff (rst)
    dens_sel == ((^$past(rate_code)) ^ $past(ident) ^ $past(invert))); // R6 R7 R8

endmodule

bind rate_clk_div rdiv_chk #(
  .DIV_1M(DIV_1M), .DIV_500(DIV_500), .DIV_300(DIV_300), .DIV_250(DIV_250),
  .WID_1M(WID_1M), .WID_500(WID_500), .WID_300(WID_300), .WID_250(WID_250)
) u_chk (
  .clk(clk), .rst(rst), .ident(ident), .invert(invert), .wr_trig(wr_trig),
  .tick(tick), .wr_pulse(wr_pulse), .rate_code(rate_code), .dens_sel(dens_sel)
);

// File: tb/rate_clk_div_tb.sv
module rate_clk_div_tb;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       rate_we = 1'b0;
  logic [1:0] rate_wdata = 2'b00;
  logic       ident = 1'b0;
  logic       invert = 1'b0;
  logic       wr_trig = 1'b0;
  logic       tick, wr_pulse, dens_sel;
  logic [1:0] rate_code;

  int total = 0;
  int bad   = 0;
  logic [1:0] exp_q[$];
  logic [1:0] drv_pend = 2'b00;

  always #4 clk = ~clk;

  rate_clk_div u_dut (
    .clk(clk), .rst(rst), .rate_we(rate_we), .rate_wdata(rate_wdata),
    .ident(ident), .invert(invert), .wr_trig(wr_trig), .tick(tick),
    .wr_pulse(wr_pulse), .rate_code(rate_code), .dens_sel(dens_sel)
  );

  // Tables from the requirements (R2, R4)
  function automatic int exp_div(logic [1:0] c);
    case (c) 2'b11: return 3; 2'b00: return 6; 2'b01: return 10; default: return 12; endcase
  endfunction
  function automatic int exp_wid(logic [1:0] c);
    case (c) 2'b11: return 5; 2'b00: return 10; 2'b01: return 16; default: return 19; endcase
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  // Monitor: tick spacing and scoreboard of adopted rate codes
  logic       seen = 1'b0;
  int         gap = 0;
  logic [1:0] prev_rc = 2'b00;
  logic [1:0] last_rc = 2'b00;
  always @(negedge clk) begin
    if (rst) begin
      seen = 1'b0; gap = 0; last_rc = 2'b00;
    end else begin
      gap++;
      if (tick) begin
        if (seen) chk(gap == exp_div(prev_rc), "R2 tick interval", gap, exp_div(prev_rc));
        seen = 1'b1; gap = 0; prev_rc = rate_code;
        if (rate_code != last_rc) begin
          if (exp_q.size() == 0) chk(1'b0, "R3 unexpected rate change", rate_code, last_rc);
          else begin
            logic [1:0] e;
            e = exp_q.pop_front();
            chk(rate_code == e, "R3 adopted code", rate_code, e);
          end
          last_rc = rate_code;
        end
      end else if (rate_code != last_rc) begin
        chk(1'b0, "R3 change off tick", rate_code, last_rc);
        last_rc = rate_code;
      end
    end
  end

  task automatic write_rate(input logic [1:0] c);
    @(negedge clk); rate_we = 1'b1; rate_wdata = c;
    @(negedge clk); rate_we = 1'b0;
    if (c != drv_pend) begin exp_q.push_back(c); drv_pend = c; end
    repeat (30) @(negedge clk);
  endtask

  // Two writes inside one tick period: only the second may land (R3)
  task automatic write_pair(input logic [1:0] a, input logic [1:0] b);
    @(negedge clk);
    while (!tick) @(negedge clk);
    rate_we = 1'b1; rate_wdata = a;
    @(negedge clk); rate_wdata = b;
    @(negedge clk); rate_we = 1'b0;
    if (b != drv_pend) begin exp_q.push_back(b); drv_pend = b; end
    repeat (30) @(negedge clk);
  endtask

  task automatic fire(input bit retrig);
    int w;
    logic [1:0] rc;
    @(negedge clk); rc = rate_code; wr_trig = 1'b1;
    @(negedge clk); wr_trig = 1'b0;
    w = 0;
    while (wr_pulse && w < 100) begin
      w++;
      wr_trig = (retrig && w == 2);
      @(negedge clk);
    end
    wr_trig = 1'b0;
    if (retrig) chk(w == exp_wid(rc), "R5 retrigger ignored width", w, exp_wid(rc));
    else        chk(w == exp_wid(rc), "R4 pulse width", w, exp_wid(rc));
    repeat (3) @(negedge clk);
    chk(!wr_pulse, "R5 no pulse without trigger", wr_pulse, 0);
  endtask

  task automatic dens_check(input logic id, input logic inv);
    logic slow, e;
    @(negedge clk); ident = id; invert = inv;
    repeat (2) @(negedge clk);
    slow = (rate_code == 2'b01) || (rate_code == 2'b10);
    e = id ? !slow : slow;
    if (inv) e = !e;
    if (!id && !inv)     chk(dens_sel == e, "R6 density level", dens_sel, e);
    else if (id && !inv) chk(dens_sel == e, "R7 density level", dens_sel, e);
    else                 chk(dens_sel == e, "R8 density inverted", dens_sel, e);
  endtask

  bit finished = 1'b0;
  task automatic wrap_up;
    if (!finished) begin
      finished = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    #(8 * 200000);
    chk(1'b0, "watchdog expired", 0, 1);
    wrap_up();
  end

  initial begin
    repeat (4) @(negedge clk);
    chk(rate_code == 2'b00, "R1 reset rate_code", rate_code, 0);
    chk(!tick, "R1 reset tick", tick, 0);
    chk(!wr_pulse, "R1 reset wr_pulse", wr_pulse, 0);
    rst = 1'b0;
    @(negedge clk);
    chk(!tick && !wr_pulse && rate_code == 2'b00, "R1 first cycle after reset",
        {tick, wr_pulse, rate_code}, 0);
    repeat (40) @(negedge clk);
    fire(1'b0);
    for (int i = 0; i < 4; i++) dens_check(i[1], i[0]);

    for (int r = 0; r < 4; r++) begin
      logic [1:0] code;
      code = (r == 0) ? 2'b11 : (r == 1) ? 2'b01 : (r == 2) ? 2'b10 : 2'b00;
      write_rate(code);
      chk(rate_code == code, "R3 rate adopted", rate_code, code);
      fire(1'b0);
      fire(1'b1);
      for (int i = 0; i < 4; i++) dens_check(i[1], i[0]);
    end

    write_rate(2'b11);
    write_pair(2'b01, 2'b10);
    chk(rate_code == 2'b10, "R3 last write wins", rate_code, 2'b10);
    write_pair(2'b11, 2'b00);
    chk(rate_code == 2'b00, "R3 last write wins", rate_code, 2'b00);
    repeat (40) @(negedge clk);
    chk(exp_q.size() == 0, "R3 all writes adopted", exp_q.size(), 0);
    wrap_up();
  end

endmodule